// File: doc/BRIEF.md
# Dual-Mode General Purpose Timer

This block is a register-programmed timer with two operating personalities selected by a configuration field. In countdown personality it builds a 32-bit reload value from two 16-bit halves. It counts down once per clock to zero, flags a timeout, and either reloads and runs on or halts after the first timeout. Each timeout can also fire a one-clock pulse on a trigger line meant for a neighbouring converter. In real-time personality the counter advances once for every cycle on which a slow tick enable input is high. That input stands in for a 1 Hz time base. When the advanced value equals the programmed 32-bit match value, a match status bit is raised.

Software talks to it over a plain synchronous bus with byte offsets. The registers are: configuration at 0x00 (bits 2:0), mode at 0x04 (bit 0 one-shot), control at 0x08 (bit 0 run, bit 5 trigger enable), interval load at 0x0C, match at 0x10, interrupt mask at 0x14, raw status at 0x18, masked status at 0x1C and a write-one-to-clear register at 0x20. Reads of unmapped offsets return zero. Writes to unmapped or read-only offsets change nothing. The interrupt output is a level that stays high while any unmasked raw status bit is set.

Top module: `gpt_timer`

## Requirements
- R1: After reset every register reads zero, and both irq and trig are low.
- R2: With configuration 0, a write that changes control bit 0 from 0 to 1 loads the counter with {load high half, load low half}. The counter then drops by one per clock. The clock in which it holds zero is a timeout, which sets raw status bit 0. In periodic mode the counter takes the load value again on the next clock, so a load of L gives one timeout every L+1 clocks.
- R3: When control bit 5 is set, each timeout produces a trig pulse of exactly one clock, in the clock after the timeout. When control bit 5 is clear, trig stays low.
- R4: When mode bit 0 is set, the counter halts after its first timeout and produces no further timeouts.
- R5: A write that changes control bit 0 from 1 to 0 halts the counter with no further timeouts. A control write that leaves bit 0 unchanged neither starts nor restarts the counter.
- R6: With configuration 1, a 0-to-1 change of control bit 0 clears the counter. The counter then advances by one on each clock with tick_en high. When the advanced value equals {match high half, match low half}, raw status bit 2 is set. No countdown timeout occurs in this configuration.
- R7: A mask write keeps only bits 0x77. The masked status register reads raw AND mask, and irq is high exactly when that value is nonzero.
- R8: Writing ones to the clear register (0x20) clears the matching raw bits. If a hardware event sets a bit in the same clock that software clears it, the bit stays set.
- R9: With configuration below 4, writes to load and match fill both halves and reads return the joined 32-bit value. With configuration 4 or above, writes change only the low half and reads return the low half with zero above it.
- R10: With a configuration value of 2, 3 or 5 to 7, a started timer produces no timeout, no match and no trig pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_en | input | 1 | Slow time-base enable used in real-time configuration |
| irq | output | 1 | Level interrupt, any unmasked raw status bit set |
| trig | output | 1 | One-clock pulse after each countdown timeout when enabled |

## Verification
A hardware status set and a software clear of the same raw bit can land on the same clock edge. The bench provokes this by counting clocks from the run write and timing a clear write so that it is captured on the very edge where the timeout sets bit 0. That is the edge L+1 clocks after the start. After that edge, raw status must still read 1, and a clear one edge away from any timeout must leave it 0. A start write can also coincide with a stop on the control register. The core resolves this in favour of whichever transition the written bit describes, and the checker ties each such write to the counter's next state.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int REG_ADDR_W = 6;

  localparam logic [REG_ADDR_W-1:0] OFS_CFG   = 6'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_MODE  = 6'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL  = 6'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_LOAD  = 6'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_MATCH = 6'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_MASK  = 6'h14;
  localparam logic [REG_ADDR_W-1:0] OFS_RAW   = 6'h18;
  localparam logic [REG_ADDR_W-1:0] OFS_MSTAT = 6'h1C;
  localparam logic [REG_ADDR_W-1:0] OFS_CLR   = 6'h20;

  localparam logic [2:0] CFG_COUNTDOWN = 3'd0;
  localparam logic [2:0] CFG_RTC       = 3'd1;
  localparam logic [2:0] CFG_SPLIT_MIN = 3'd4;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_TRIG_BIT = 5;
  localparam int MODE_ONESHOT_BIT = 0;

  localparam int RAW_W           = 7;
  localparam int RAW_TIMEOUT_BIT = 0;
  localparam int RAW_MATCH_BIT   = 2;
  localparam logic [RAW_W-1:0] MASK_KEEP = 7'h77;
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [REG_ADDR_W-1:0]  addr,
  input  logic                   we,
  input  logic [2*HALF_W-1:0]    wdata,
  output logic [2*HALF_W-1:0]    rdata,
  input  logic [RAW_W-1:0]       raw,
  input  logic [RAW_W-1:0]       masked,
  output logic [2:0]             cfg,
  output logic                   oneshot,
  output logic                   trig_en,
  output logic                   run_rise,
  output logic                   run_fall,
  output logic [2*HALF_W-1:0]    load_val,
  output logic [2*HALF_W-1:0]    match_val,
  output logic [RAW_W-1:0]       mask,
  output logic [RAW_W-1:0]       clr_bits
);
  localparam int DW = 2 * HALF_W;

  logic [2:0]        cfg_q;
  logic              oneshot_q;
  logic              run_q;
  logic              trig_q;
  logic [HALF_W-1:0] load_lo, load_hi, match_lo, match_hi;
  logic [RAW_W-1:0]  mask_q;

  function automatic logic [DW-1:0] join_halves(input logic [HALF_W-1:0] lo,
                                                 input logic [HALF_W-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [DW-1:0] read_pair(input logic [HALF_W-1:0] lo,
                                               input logic [HALF_W-1:0] hi,
                                               input logic [2:0] c);
    return (c < CFG_SPLIT_MIN) ? {hi, lo} : {{HALF_W{1'b0}}, lo};
  endfunction

  function automatic logic [DW-1:0] widen_raw(input logic [RAW_W-1:0] v);
    return {{(DW-RAW_W){1'b0}}, v};
  endfunction

  logic hit_cfg, hit_mode, hit_ctrl, hit_load, hit_match, hit_mask, hit_clr;
  logic wide_cfg;

  assign hit_cfg   = we && (addr == OFS_CFG);
  assign hit_mode  = we && (addr == OFS_MODE);
  assign hit_ctrl  = we && (addr == OFS_CTRL);
  assign hit_load  = we && (addr == OFS_LOAD);
  assign hit_match = we && (addr == OFS_MATCH);
  assign hit_mask  = we && (addr == OFS_MASK);
  assign hit_clr   = we && (addr == OFS_CLR);
  assign wide_cfg  = (cfg_q < CFG_SPLIT_MIN);

  assign run_rise = hit_ctrl && wdata[CTRL_RUN_BIT] && !run_q;
  assign run_fall = hit_ctrl && !wdata[CTRL_RUN_BIT] && run_q;
  assign clr_bits = hit_clr ? wdata[RAW_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      oneshot_q <= 1'b0;
      run_q     <= 1'b0;
      trig_q    <= 1'b0;
      load_lo   <= '0;
      load_hi   <= '0;
      match_lo  <= '0;
      match_hi  <= '0;
      mask_q    <= '0;
    end else begin
      if (hit_cfg)  cfg_q     <= wdata[2:0];
      if (hit_mode) oneshot_q <= wdata[MODE_ONESHOT_BIT];
      if (hit_ctrl) begin
        run_q  <= wdata[CTRL_RUN_BIT];
        trig_q <= wdata[CTRL_TRIG_BIT];
      end
      if (hit_load) begin
        load_lo <= wdata[HALF_W-1:0];
        if (wide_cfg) load_hi <= wdata[DW-1:HALF_W];
      end
      if (hit_match) begin
        match_lo <= wdata[HALF_W-1:0];
        if (wide_cfg) match_hi <= wdata[DW-1:HALF_W];
      end
      if (hit_mask) mask_q <= wdata[RAW_W-1:0] & MASK_KEEP;
    end
  end

  logic [DW-1:0] ctrl_rd;
  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_RUN_BIT]  = run_q;
    ctrl_rd[CTRL_TRIG_BIT] = trig_q;
  end

  always_comb begin
    case (addr)
      OFS_CFG:   rdata = {{(DW-3){1'b0}}, cfg_q};
      OFS_MODE:  rdata = {{(DW-1){1'b0}}, oneshot_q};
      OFS_CTRL:  rdata = ctrl_rd;
      OFS_LOAD:  rdata = read_pair(load_lo, load_hi, cfg_q);
      OFS_MATCH: rdata = read_pair(match_lo, match_hi, cfg_q);
      OFS_MASK:  rdata = widen_raw(mask_q);
      OFS_RAW:   rdata = widen_raw(raw);
      OFS_MSTAT: rdata = widen_raw(masked);
      default:   rdata = '0;
    endcase
  end

  assign cfg       = cfg_q;
  assign oneshot   = oneshot_q;
  assign trig_en   = trig_q;
  assign load_val  = join_halves(load_lo, load_hi);
  assign match_val = join_halves(match_lo, match_hi);
  assign mask      = mask_q;
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg,
  input  logic                oneshot,
  input  logic                trig_en,
  input  logic                run_rise,
  input  logic                run_fall,
  input  logic                tick_en,
  input  logic [2*HALF_W-1:0] load_val,
  input  logic [2*HALF_W-1:0] match_val,
  output logic                timeout_evt,
  output logic                match_evt,
  output logic                trig,
  output logic                active,
  output logic [2*HALF_W-1:0] cnt
);
  localparam int CW = 2 * HALF_W;

  function automatic logic [CW-1:0] rtc_next(input logic [CW-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic [CW-1:0] down_next(input logic [CW-1:0] c);
    return c - 1'b1;
  endfunction

  logic is_cd, is_rtc, quiet_write;
  assign is_cd       = (cfg == CFG_COUNTDOWN);
  assign is_rtc      = (cfg == CFG_RTC);
  assign quiet_write = !run_rise && !run_fall;

  assign timeout_evt = active && is_cd && (cnt == '0) && quiet_write;
  assign match_evt   = active && is_rtc && tick_en && quiet_write &&
                       (rtc_next(cnt) == match_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      trig   <= 1'b0;
    end else begin
      trig <= timeout_evt && trig_en;
      if (run_rise) begin
        active <= 1'b1;
        cnt    <= is_rtc ? '0 : load_val;
      end else if (run_fall) begin
        active <= 1'b0;
      end else if (active) begin
        if (is_cd) begin
          if (cnt == '0) begin
            if (oneshot) active <= 1'b0;
            else         cnt    <= load_val;
          end else begin
            cnt <= down_next(cnt);
          end
        end else if (is_rtc && tick_en) begin
          cnt <= rtc_next(cnt);
        end
      end
    end
  end
endmodule

// File: rtl/gpt_irq.sv
module gpt_irq
  import gpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             timeout_evt,
  input  logic             match_evt,
  input  logic [RAW_W-1:0] clr_bits,
  input  logic [RAW_W-1:0] mask,
  output logic [RAW_W-1:0] raw,
  output logic [RAW_W-1:0] masked,
  output logic             irq
);
  function automatic logic [RAW_W-1:0] apply_mask(input logic [RAW_W-1:0] r,
                                                   input logic [RAW_W-1:0] m);
    return r & m;
  endfunction

  logic [RAW_W-1:0] set_vec;

  for (genvar i = 0; i < RAW_W; i++) begin : g_src
    if (i == RAW_TIMEOUT_BIT) begin : g_to
      assign set_vec[i] = timeout_evt;
    end else if (i == RAW_MATCH_BIT) begin : g_mt
      assign set_vec[i] = match_evt;
    end else begin : g_none
      assign set_vec[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr_bits) | set_vec;
  end

  assign masked = apply_mask(raw, mask);
  assign irq    = |masked;
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [2*HALF_W-1:0]   bus_wdata,
  output logic [2*HALF_W-1:0]   bus_rdata,
  input  logic                  tick_en,
  output logic                  irq,
  output logic                  trig
);
  localparam int DW = 2 * HALF_W;

  logic [2:0]       cfg;
  logic             oneshot, trig_en, run_rise, run_fall;
  logic [DW-1:0]    load_val, match_val, cnt;
  logic [RAW_W-1:0] mask, clr_bits, raw, masked;
  logic             timeout_evt, match_evt, active;

  gpt_regs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .rdata(bus_rdata), .raw(raw), .masked(masked),
    .cfg(cfg), .oneshot(oneshot), .trig_en(trig_en),
    .run_rise(run_rise), .run_fall(run_fall),
    .load_val(load_val), .match_val(match_val),
    .mask(mask), .clr_bits(clr_bits)
  );

  gpt_core #(.HALF_W(HALF_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .oneshot(oneshot),
    .trig_en(trig_en), .run_rise(run_rise), .run_fall(run_fall),
    .tick_en(tick_en), .load_val(load_val), .match_val(match_val),
    .timeout_evt(timeout_evt), .match_evt(match_evt), .trig(trig),
    .active(active), .cnt(cnt)
  );

  gpt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .timeout_evt(timeout_evt),
    .match_evt(match_evt), .clr_bits(clr_bits), .mask(mask),
    .raw(raw), .masked(masked), .irq(irq)
  );
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk
  import gpt_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          cfg,
  input logic                oneshot,
  input logic                trig_en,
  input logic                run_rise,
  input logic                run_fall,
  input logic [2*HALF_W-1:0] load_val,
  input logic [2*HALF_W-1:0] cnt,
  input logic                active,
  input logic                timeout_evt,
  input logic                match_evt,
  input logic [RAW_W-1:0]    raw,
  input logic [RAW_W-1:0]    clr_bits,
  input logic                irq,
  input logic                trig
);
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_rise && cfg == CFG_COUNTDOWN) |=> (active && cnt == $past(load_val))); // R2
  AST_TIMEOUT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> raw[RAW_TIMEOUT_BIT]); // R2
  AST_TRIG_FROM_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(timeout_evt) && $past(trig_en))); // R3
  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && oneshot) |=> !active); // R4
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    run_fall |=> !active); // R5
  AST_MATCH_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> raw[RAW_MATCH_BIT]); // R6
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw != '0)); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits[RAW_TIMEOUT_BIT] && !timeout_evt) |=> !raw[RAW_TIMEOUT_BIT]); // R8
endmodule

bind gpt_timer gpt_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .oneshot(oneshot), .trig_en(trig_en),
  .run_rise(run_rise), .run_fall(run_fall), .load_val(load_val), .cnt(cnt),
  .active(active), .timeout_evt(timeout_evt), .match_evt(match_evt),
  .raw(raw), .clr_bits(clr_bits), .irq(irq), .trig(trig)
);

// File: tb/tb_gpt_timer.sv
module tb_gpt_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        irq, trig;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_trig[$];

  gpt_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .irq(irq), .trig(trig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic tick;
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  // Monitor: every trig pulse must match the next expected cycle.
  always @(negedge clk) begin
    if (rst_n && trig) begin
      total++;
      if (exp_trig.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected trig actual=cyc%0d expected=none", cyc);
      end else begin
        int e;
        e = exp_trig.pop_front();
        if (e != cyc) begin
          bad++;
          $display("FAIL R3 trig cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 cfg", 6'h00, 32'h0);
    rd_chk("R1 ctrl", 6'h08, 32'h0);
    rd_chk("R1 load", 6'h0C, 32'h0);
    rd_chk("R1 mask", 6'h14, 32'h0);
    rd_chk("R1 raw", 6'h18, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 trig", {31'b0, trig}, 32'h0);

    // R7 mask filtering
    wr(6'h14, 32'hFFFF_FFFF);
    rd_chk("R7 mask keep", 6'h14, 32'h77);

    // R9 joined and split access
    wr(6'h0C, 32'hABCD_1234);
    rd_chk("R9 load joined", 6'h0C, 32'hABCD_1234);
    wr(6'h10, 32'h0005_0006);
    rd_chk("R9 match joined", 6'h10, 32'h0005_0006);
    wr(6'h00, 32'h4);
    rd_chk("R9 load low only", 6'h0C, 32'h0000_1234);
    wr(6'h0C, 32'h5555_6666);
    wr(6'h00, 32'h0);
    rd_chk("R9 high half kept", 6'h0C, 32'hABCD_6666);

    // R2/R3 periodic countdown, L=4
    wr(6'h0C, 32'd4);
    wr(6'h04, 32'h0);
    wr(6'h08, 32'h21);
    c0 = cyc;
    exp_trig.push_back(c0 + 5);
    exp_trig.push_back(c0 + 10);
    exp_trig.push_back(c0 + 15);
    wait_to(c0 + 16);
    wr(6'h08, 32'h20); // R5 stop before next timeout
    repeat (12) @(negedge clk);
    chk("R3 R5 pending trig", exp_trig.size(), 0);
    rd_chk("R2 raw timeout", 6'h18, 32'h1);
    rd_chk("R7 masked status", 6'h1C, 32'h1);
    chk("R7 irq high", {31'b0, irq}, 32'h1);

    // R8 clear
    wr(6'h20, 32'h1);
    rd_chk("R8 raw cleared", 6'h18, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);

    // R5 unchanged run bit does not start
    wr(6'h08, 32'h20);
    repeat (10) @(negedge clk);
    rd_chk("R5 no restart", 6'h18, 32'h0);

    // R4 one-shot, L=3
    wr(6'h04, 32'h1);
    wr(6'h0C, 32'd3);
    wr(6'h08, 32'h21);
    c0 = cyc;
    exp_trig.push_back(c0 + 4);
    repeat (20) @(negedge clk);
    chk("R4 single trig", exp_trig.size(), 0);
    rd_chk("R4 raw", 6'h18, 32'h1);
    wr(6'h08, 32'h0);
    wr(6'h20, 32'h1);

    // R3 trigger disabled: timeouts but no pulse
    wr(6'h04, 32'h0);
    wr(6'h0C, 32'd2);
    wr(6'h08, 32'h01);
    repeat (10) @(negedge clk);
    rd_chk("R3 raw without trig", 6'h18, 32'h1);
    wr(6'h08, 32'h0);
    wr(6'h20, 32'h1);
    rd_chk("R8 clear after stop", 6'h18, 32'h0);

    // R8 set and clear in the same clock: set wins
    wr(6'h0C, 32'd4);
    wr(6'h08, 32'h01);
    c0 = cyc;
    wait_to(c0 + 3);
    wr(6'h20, 32'h1); // captured on edge c0+5, the timeout edge
    rd_chk("R8 set beats clear", 6'h18, 32'h1);
    wr(6'h08, 32'h0);
    wr(6'h20, 32'h1);
    rd_chk("R8 plain clear", 6'h18, 32'h0);

    // R6 real-time match
    wr(6'h00, 32'h1);
    wr(6'h10, 32'd3);
    wr(6'h08, 32'h21);
    tick; tick;
    rd_chk("R6 before match", 6'h18, 32'h0);
    tick;
    rd_chk("R6 match raw", 6'h18, 32'h4);
    chk("R6 irq", {31'b0, irq}, 32'h1);
    repeat (8) @(negedge clk);
    rd_chk("R6 no countdown timeout", 6'h18, 32'h4);
    wr(6'h14, 32'h0);
    chk("R7 irq masked off", {31'b0, irq}, 32'h0);
    rd_chk("R7 masked zero", 6'h1C, 32'h0);
    rd_chk("R7 raw kept", 6'h18, 32'h4);
    wr(6'h08, 32'h0);
    wr(6'h20, 32'h4);
    wr(6'h14, 32'h77);

    // R10 unsupported configuration stays quiet
    wr(6'h00, 32'h2);
    wr(6'h10, 32'd1);
    wr(6'h0C, 32'd1);
    wr(6'h08, 32'h21);
    tick; tick;
    repeat (20) @(negedge clk);
    rd_chk("R10 quiet raw", 6'h18, 32'h0);
    chk("R10 quiet irq", {31'b0, irq}, 32'h0);
    wr(6'h08, 32'h0);

    chk("R3 queue drained", exp_trig.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule